// File: doc/BRIEF.md
# Address-Event Synapse Stimulus Decoder

This block accepts pre-synaptic address events on a four-phase request/acknowledge handshake and turns each into one synapse stimulus. An event names a destination neuron, a column of the weight memory, a synapse kind with a physical synapse index, and a weight value. The block holds a matrix of small unsigned weights with one row per neuron. It issues a stimulus strobe that carries the neuron, the synapse index, the kind and the effective weight to the downstream synapse logic.

A mode input sets where the effective weight comes from. In pass-through mode the weight carried in the event is used directly. If the commit input is also set, that weight is written into the addressed cell, so a trained matrix builds up during online learning. In stored mode the event's weight bits are ignored and the addressed cell is read. This lets the same event format drive standalone inference.

Both mode inputs are sampled once, when an event is captured. An event is acknowledged only after the downstream side has accepted its stimulus.

Top module: `aer_synapse_decoder`

## Requirements
- R1: The 18-bit event is split as follows: bits 17:13 are the neuron (row), bits 12:8 the memory column, bit 7 the kind (1 excitatory, 0 inhibitory), bits 6:5 the physical synapse index, and bits 4:0 the weight. The stimulus presents the neuron, index and kind exactly as carried.
- R2: In pass-through mode (`storeMode` = 0) the stimulus weight equals the event's weight field.
- R3: In stored mode (`storeMode` = 1) the event's weight field is ignored, and the stimulus weight is the value held at row = neuron, column = column.
- R4: A pass-through event with `commitWeight` = 1 writes its weight into the addressed cell. With `commitWeight` = 0 the cell is left unchanged.
- R5: A stored-mode event never changes any cell, whatever the value of `commitWeight`.
- R6: After reset every cell reads 0.
- R7: `stimValid` stays high with a stable payload until `stimReady` is seen. `evtAck` rises only in the cycle after the stimulus is accepted and is never high together with `stimValid`.
- R8: After `evtAck` rises it stays high until `evtReq` falls. No new stimulus is issued before that.
- R9: `storeMode` and `commitWeight` are sampled at event capture. Changing them during an event does not affect it.
- R10: During reset and right after it, `stimValid` and `evtAck` are low.
- R11: `stimValid` rises one cycle after the capture edge in pass-through mode and two cycles after it in stored mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtReq | input | 1 | Event request (four-phase) |
| evtData | input | 18 | Event word |
| evtAck | output | 1 | Event acknowledge |
| storeMode | input | 1 | 1 = use stored weight, 0 = use event weight |
| commitWeight | input | 1 | In pass-through mode, also write the event weight |
| stimValid | output | 1 | Stimulus strobe |
| stimReady | input | 1 | Downstream accepts the stimulus |
| stimNeuron | output | 5 | Target neuron |
| stimSynIdx | output | 2 | Physical synapse index |
| stimExcite | output | 1 | 1 excitatory, 0 inhibitory |
| stimWeight | output | 5 | Effective weight |

## Verification
The checker watches the handshake on every cycle:
- a held, stable stimulus while backpressured;
- an acknowledge only after acceptance and never alongside the strobe;
- an acknowledge held until the request drops;
- quiet outputs in reset.

The following can only be shown by the bench's scenarios, using a scoreboard with its own weight model:
- the field split and the choice between event weight and stored weight;
- commits and their absence;
- zeroed memory after reset;
- mode sampling at capture;
- the one-cycle versus two-cycle latency.

// File: rtl/aer_dec_pkg.sv
package aer_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_OFFER = 2'd2,
    ST_ACK   = 2'd3
  } decState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch the incoming event word
    logic writeEn;    // commit event weight into memory
    logic readEn;     // look up stored weight
    logic offer;      // stimulus valid
    logic ack;        // acknowledge to sender
    logic useStored;  // effective weight comes from memory
  } ctrlStrobes_t;

endpackage

// File: rtl/aer_dec_weight_mem.sv
module aer_dec_weight_mem #(
  parameter int ROWS      = 32,
  parameter int COLS      = 32,
  parameter int WEIGHT_W  = 5,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ROW_W-1:0]    wrRow,
  input  logic [COL_W-1:0]    wrCol,
  input  logic [WEIGHT_W-1:0] wrData,
  input  logic                rdEn,
  input  logic [ROW_W-1:0]    rdRow,
  input  logic [COL_W-1:0]    rdCol,
  output logic [WEIGHT_W-1:0] rdData
);

  logic [WEIGHT_W-1:0] cells [ROWS][COLS];

  // one row of storage per neuron
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int c = 0; c < COLS; c++) cells[r][c] <= '0;
      end else if (wrEn && (wrRow == ROW_W'(r))) begin
        cells[r][wrCol] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= cells[rdRow][rdCol];
  end

endmodule

// File: rtl/aer_dec_ctrl.sv
module aer_dec_ctrl
  import aer_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtReq,
  input  logic         stimReady,
  input  logic         storeMode,
  input  logic         commitWeight,
  output ctrlStrobes_t strobes
);

  decState_t state, stateNext;
  logic      modeStored;
  logic      capture;

  assign capture = (state == ST_IDLE) && evtReq;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (evtReq) stateNext = storeMode ? ST_READ : ST_OFFER;
      ST_READ:  stateNext = ST_OFFER;
      ST_OFFER: if (stimReady) stateNext = ST_ACK;
      ST_ACK:   if (!evtReq) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      modeStored <= 1'b0;
    end else begin
      state <= stateNext;
      if (capture) modeStored <= storeMode;
    end
  end

  always_comb begin
    strobes.capture   = capture;
    strobes.writeEn   = capture && !storeMode && commitWeight;
    strobes.readEn    = (state == ST_READ);
    strobes.offer     = (state == ST_OFFER);
    strobes.ack       = (state == ST_ACK);
    strobes.useStored = modeStored;
  end

endmodule

// File: rtl/aer_dec_datapath.sv
module aer_dec_datapath
  import aer_dec_pkg::*;
#(
  parameter int NEURONS   = 32,
  parameter int COLUMNS   = 32,
  parameter int WEIGHT_W  = 5,
  parameter int SYN_IDX_W = 2,
  localparam int NEURON_W = $clog2(NEURONS),
  localparam int COL_W    = $clog2(COLUMNS),
  localparam int EVT_W    = NEURON_W + COL_W + 1 + SYN_IDX_W + WEIGHT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [EVT_W-1:0]     evtData,
  output logic [NEURON_W-1:0]  stimNeuron,
  output logic [SYN_IDX_W-1:0] stimSynIdx,
  output logic                 stimExcite,
  output logic [WEIGHT_W-1:0]  stimWeight
);

  // field positions, weight at the bottom
  localparam int W_LO   = 0;
  localparam int IDX_LO = WEIGHT_W;
  localparam int KIND_B = IDX_LO + SYN_IDX_W;
  localparam int COL_LO = KIND_B + 1;
  localparam int NEU_LO = COL_LO + COL_W;

  logic [EVT_W-1:0]    evtReg;
  logic [WEIGHT_W-1:0] storedWeight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               evtReg <= '0;
    else if (strobes.capture) evtReg <= evtData;
  end

  aer_dec_weight_mem #(
    .ROWS     (NEURONS),
    .COLS     (COLUMNS),
    .WEIGHT_W (WEIGHT_W)
  ) u_mem (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobes.writeEn),
    .wrRow  (evtData[NEU_LO +: NEURON_W]),
    .wrCol  (evtData[COL_LO +: COL_W]),
    .wrData (evtData[W_LO +: WEIGHT_W]),
    .rdEn   (strobes.readEn),
    .rdRow  (evtReg[NEU_LO +: NEURON_W]),
    .rdCol  (evtReg[COL_LO +: COL_W]),
    .rdData (storedWeight)
  );

  assign stimNeuron = evtReg[NEU_LO +: NEURON_W];
  assign stimSynIdx = evtReg[IDX_LO +: SYN_IDX_W];
  assign stimExcite = evtReg[KIND_B];
  assign stimWeight = strobes.useStored ? storedWeight : evtReg[W_LO +: WEIGHT_W];

endmodule

// File: rtl/aer_synapse_decoder.sv
module aer_synapse_decoder
  import aer_dec_pkg::*;
#(
  parameter int NEURONS   = 32,
  parameter int COLUMNS   = 32,
  parameter int WEIGHT_W  = 5,
  parameter int SYN_IDX_W = 2,
  localparam int NEURON_W = $clog2(NEURONS),
  localparam int COL_W    = $clog2(COLUMNS),
  localparam int EVT_W    = NEURON_W + COL_W + 1 + SYN_IDX_W + WEIGHT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtReq,
  input  logic [EVT_W-1:0]     evtData,
  output logic                 evtAck,
  input  logic                 storeMode,
  input  logic                 commitWeight,
  output logic                 stimValid,
  input  logic                 stimReady,
  output logic [NEURON_W-1:0]  stimNeuron,
  output logic [SYN_IDX_W-1:0] stimSynIdx,
  output logic                 stimExcite,
  output logic [WEIGHT_W-1:0]  stimWeight
);

  ctrlStrobes_t strobes;

  aer_dec_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .evtReq       (evtReq),
    .stimReady    (stimReady),
    .storeMode    (storeMode),
    .commitWeight (commitWeight),
    .strobes      (strobes)
  );

  aer_dec_datapath #(
    .NEURONS   (NEURONS),
    .COLUMNS   (COLUMNS),
    .WEIGHT_W  (WEIGHT_W),
    .SYN_IDX_W (SYN_IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .evtData    (evtData),
    .stimNeuron (stimNeuron),
    .stimSynIdx (stimSynIdx),
    .stimExcite (stimExcite),
    .stimWeight (stimWeight)
  );

  assign stimValid = strobes.offer;
  assign evtAck    = strobes.ack;

endmodule

// File: rtl/aer_synapse_decoder_checker.sv
module aer_synapse_decoder_checker #(
  parameter int NEURON_W  = 5,
  parameter int SYN_IDX_W = 2,
  parameter int WEIGHT_W  = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 evtReq,
  input logic                 evtAck,
  input logic                 stimValid,
  input logic                 stimReady,
  input logic [NEURON_W-1:0]  stimNeuron,
  input logic [SYN_IDX_W-1:0] stimSynIdx,
  input logic                 stimExcite,
  input logic [WEIGHT_W-1:0]  stimWeight
);

  assert_stim_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stimValid && !stimReady) |=> (stimValid && $stable(stimNeuron) && $stable(stimSynIdx)
                                   && $stable(stimExcite) && $stable(stimWeight)));

  assert_ack_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtAck) |-> $past(stimValid && stimReady));

  assert_no_ack_with_stim_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(evtAck && stimValid));

  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtAck && evtReq) |=> (evtAck && !stimValid));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R10: assert (!stimValid && !evtAck);
    end
  end

endmodule

bind aer_synapse_decoder aer_synapse_decoder_checker #(
  .NEURON_W  (NEURON_W),
  .SYN_IDX_W (SYN_IDX_W),
  .WEIGHT_W  (WEIGHT_W)
) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .evtReq     (evtReq),
  .evtAck     (evtAck),
  .stimValid  (stimValid),
  .stimReady  (stimReady),
  .stimNeuron (stimNeuron),
  .stimSynIdx (stimSynIdx),
  .stimExcite (stimExcite),
  .stimWeight (stimWeight)
);

// File: tb/test_aer_synapse_decoder.sv
module test_aer_synapse_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtReq = 1'b0;
  logic [17:0] evtData = '0;
  logic        evtAck;
  logic        storeMode = 1'b0;
  logic        commitWeight = 1'b0;
  logic        stimValid;
  logic        stimReady = 1'b1;
  logic [4:0]  stimNeuron;
  logic [1:0]  stimSynIdx;
  logic        stimExcite;
  logic [4:0]  stimWeight;

  int checks = 0;
  int fails  = 0;
  logic [4:0]  model [32][32];
  logic [12:0] expQ[$];   // {neuron, idx, excite, weight}

  always #2 clk = ~clk;   // 250 MHz

  aer_synapse_decoder i_aer_synapse_decoder (
    .clk(clk), .rstN(rstN), .evtReq(evtReq), .evtData(evtData), .evtAck(evtAck),
    .storeMode(storeMode), .commitWeight(commitWeight), .stimValid(stimValid),
    .stimReady(stimReady), .stimNeuron(stimNeuron), .stimSynIdx(stimSynIdx),
    .stimExcite(stimExcite), .stimWeight(stimWeight)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: sample 1 ns before each rising edge
  always @(negedge clk) begin
    #1;
    if (rstN && stimValid && stimReady) begin
      logic [12:0] got;
      got = {stimNeuron, stimSynIdx, stimExcite, stimWeight};
      if (expQ.size() == 0) check(1'b0, "R1/R2/R3 unexpected stimulus", int'(got), -1);
      else begin
        logic [12:0] exp;
        exp = expQ.pop_front();
        check(got[12:5] == exp[12:5], "R1 fields", int'(got[12:5]), int'(exp[12:5]));
        check(got[4:0] == exp[4:0], "R2/R3/R4/R5/R6/R9 weight", int'(got[4:0]), int'(exp[4:0]));
      end
    end
  end

  // driver: predict, then run the four-phase handshake
  task automatic sendEvent(input logic [4:0] n, input logic [4:0] col, input logic kind,
                           input logic [1:0] idx, input logic [4:0] w, input int holdAfterAck);
    logic [4:0] expW;
    int lat;
    bit stored;
    stored = storeMode;
    if (stored) expW = model[n][col];
    else begin
      expW = w;
      if (commitWeight) model[n][col] = w;
    end
    expQ.push_back({n, idx, kind, expW});
    @(negedge clk);
    evtData = {n, col, kind, idx, w};
    evtReq  = 1'b1;
    lat = 0;
    do begin
      @(negedge clk); #1; lat++;
    end while (!stimValid && lat < 50);
    check(lat == (stored ? 2 : 1), "R11 latency", lat, stored ? 2 : 1);
    while (!evtAck) begin @(negedge clk); #1; end
    for (int i = 0; i < holdAfterAck; i++) begin
      @(negedge clk); #1;
      check(evtAck && !stimValid, "R8 ack held", int'({evtAck, stimValid}), 2);
    end
    @(negedge clk);
    evtReq = 1'b0;
    do begin @(negedge clk); #1; end while (evtAck);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) for (int c = 0; c < 32; c++) model[r][c] = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!stimValid && !evtAck, "R10 reset quiet", int'({stimValid, evtAck}), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    check(!stimValid && !evtAck, "R10 after reset", int'({stimValid, evtAck}), 0);

    // R6: stored reads after reset give 0
    storeMode = 1'b1;
    sendEvent(5'd3, 5'd7, 1'b1, 2'd1, 5'd31, 0);
    sendEvent(5'd31, 5'd31, 1'b0, 2'd3, 5'd17, 0);

    // R2/R4: pass-through with commit
    storeMode = 1'b0; commitWeight = 1'b1;
    sendEvent(5'd3, 5'd7, 1'b1, 2'd2, 5'd21, 0);
    sendEvent(5'd0, 5'd0, 1'b0, 2'd0, 5'd31, 0);
    sendEvent(5'd31, 5'd31, 1'b1, 2'd3, 5'd9, 2);   // R8 hold
    // R4: pass-through without commit leaves cell
    commitWeight = 1'b0;
    sendEvent(5'd3, 5'd7, 1'b0, 2'd1, 5'd4, 0);

    // R3/R5: stored mode ignores event weight and commit
    storeMode = 1'b1; commitWeight = 1'b1;
    sendEvent(5'd3, 5'd7, 1'b1, 2'd0, 5'd1, 0);     // expect 21
    sendEvent(5'd0, 5'd0, 1'b1, 2'd2, 5'd2, 0);     // expect 31
    sendEvent(5'd31, 5'd31, 1'b0, 2'd1, 5'd0, 0);   // expect 9
    sendEvent(5'd3, 5'd7, 1'b0, 2'd3, 5'd30, 0);    // R5: still 21

    // R7/R9: backpressure, with mode flipped mid-event
    stimReady = 1'b0;
    fork
      sendEvent(5'd0, 5'd0, 1'b1, 2'd1, 5'd12, 0);  // stored: expect 31
      begin
        repeat (4) @(negedge clk);
        storeMode = 1'b0; commitWeight = 1'b1;
        #1;
        check(stimValid && !evtAck, "R7 stall no ack", int'({stimValid, evtAck}), 2);
        @(negedge clk); #1;
        check(stimWeight == 5'd31, "R9 mode sampled at capture", int'(stimWeight), 31);
        stimReady = 1'b1;
      end
    join
    // R9: the flipped mode now applies; a pass-through commit does not disturb earlier result
    sendEvent(5'd5, 5'd6, 1'b0, 2'd2, 5'd14, 0);
    storeMode = 1'b1;
    sendEvent(5'd5, 5'd6, 1'b1, 2'd0, 5'd0, 0);     // expect 14

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1 all stimuli seen", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule